// File: doc/BRIEF.md
# Boost PFC Critical-Conduction Pulse Controller

This block generates the gate pulse for the switch of a boost power-factor-correction stage that runs at the edge of critical conduction. It takes digitized samples of the rectified line (haversine) and of the DC bus, each with a valid strobe, plus a one-cycle zero-crossing pulse derived from the inductor secondary winding. It produces one gate-drive signal, a flag that shows closed-loop operation, and a fault flag.

The line is judged over repeating measurement windows. A window whose peak lies inside the allowed band lets a soft-start burst of fixed pulses begin. A burst that does not lead to regulation is followed by a long pause and then repeated, up to a bounded number of attempts. In closed loop, the on-time is proportional to the bus error, is latched only when the haversine passes through its null, and is limited by a ceiling that falls as the line peak rises. Each pulse starts on a zero crossing, or after a timeout so that the loop cannot stall. A bus overshoot blanks all pulses.

All times are given in microseconds and converted to clock cycles through the `CLK_MHZ` parameter. All voltage thresholds are ADC codes.

Top module: `pfc_crm_ctrl`

## Requirements
- R1: No gate pulse occurs until a measurement window of `WIN_US` has ended with a peak haversine code p such that `LINE_LO <= p <= LINE_HI`. The peak is the maximum of the valid samples inside that window.
- R2: When any window ends out of band (outside R1), and the block is not in the problem state, `pfc_fault` goes to 1, `pfc_running` goes to 0 and the gate stays low. The next in-band window clears `pfc_fault` and starts soft start again.
- R3: Soft start drives pulses `SS_ON_US` long, with rising edges `SS_PER_US` apart, for a burst of `SS_LEN_US`. The default values give 16 pulses of 10 us every 50 us.
- R4: A burst that ends without entering closed loop keeps the gate low for `RETRY_US` and then repeats. When burst number `MAX_TRY` fails, the block enters a problem state that holds `pfc_fault` at 1, `pfc_running` at 0 and the gate low until reset.
- R5: Closed loop (`pfc_running` = 1) starts during a burst only after a zero crossing has been seen in that burst and the last bus code b meets both `b >= BUS_SET` and `20*b >= 19*p`.
- R6: The closed-loop on-time in cycles is `((BUS_SET - b) * GAIN_MUL) >> GAIN_SH`, with the error taken as 0 when `b >= BUS_SET`. It is recomputed only at a haversine null, which is a valid sample at or below `NULL_TH` that directly follows a valid sample above it.
- R7: That on-time is limited to the smaller of `(TON_K * CLK_MHZ) / p` and `TON_CAP_US * CLK_MHZ` cycles.
- R8: While the last bus code is at or above `BUS_OVR`, the gate is low from the second clock edge onward. An on-time computed at a null during overshoot is 0.
- R9: In closed loop, a pulse starts on a zero-crossing pulse that arrives after the previous pulse has ended and lasts exactly the latched on-time. A zero crossing during a pulse has no effect.
- R10: If no zero crossing arrives for `TO_US` after a closed-loop pulse ends, the next pulse starts anyway. No pulse starts while the on-time is 0.
- R11: During and directly after reset, the gate, `pfc_running` and `pfc_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hav_vld | input | 1 | Haversine sample strobe |
| hav_code | input | ADC_W | Haversine sample code |
| bus_vld | input | 1 | Bus sample strobe |
| bus_code | input | ADC_W | Bus sample code |
| zc_pulse | input | 1 | Inductor current zero-crossing pulse, one cycle |
| gate_drv | output | 1 | Switch gate drive |
| pfc_running | output | 1 | Closed-loop regulation active |
| pfc_fault | output | 1 | Line out of band or attempts exhausted |

## Verification
The bench builds the block with `CLK_MHZ` = 1, a 300-cycle window, a 200-cycle retry pause, three attempts and a 100-cycle timeout. The full soft-start burst, the retry schedule and the problem state therefore fit within a few thousand cycles. It uses `TON_K` = 5736, `GAIN_MUL` = 3 and `GAIN_SH` = 2. These values make the line-peak ceiling (9 cycles at peak 600, 16 at peak 340) and the gain path (4 cycles at an error of 6) produce different, exactly predictable pulse widths. With these small counts, every pulse width and every gap in each burst can be measured and compared with arithmetic expected values.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [2:0] {
    ST_CHECK = 3'd0,
    ST_SOFT  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_LOCK  = 3'd4
  } pfc_state_e;
endpackage

// File: rtl/pfc_line_mon.sv
module pfc_line_mon #(
  parameter int ADC_W   = 10,
  parameter int WIN_CYC = 1000,
  parameter int LINE_LO = 324,
  parameter int LINE_HI = 956,
  parameter int NULL_TH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hav_vld,
  input  logic [ADC_W-1:0] hav_code,
  output logic [ADC_W-1:0] peak_o,
  output logic             win_done_o,
  output logic             line_ok_o,
  output logic             null_o
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam logic [WW-1:0]    WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [ADC_W-1:0] LO_V     = ADC_W'(LINE_LO);
  localparam logic [ADC_W-1:0] HI_V     = ADC_W'(LINE_HI);
  localparam logic [ADC_W-1:0] NULL_V   = ADC_W'(NULL_TH);

  logic [WW-1:0]    wcnt_q, wcnt_n;
  logic [ADC_W-1:0] acc_q, acc_n, acc_upd, peak_q, peak_n;
  logic             done_q, done_n, ok_q, ok_n, above_q, above_n, null_q, null_n;
  logic             wend;

  always_comb begin
    wend    = (wcnt_q == WIN_LAST);
    acc_upd = (hav_vld && (hav_code > acc_q)) ? hav_code : acc_q;
    wcnt_n  = wend ? '0 : wcnt_q + 1'b1;
    acc_n   = wend ? '0 : acc_upd;
    peak_n  = wend ? acc_upd : peak_q;
    done_n  = wend;
    ok_n    = wend ? ((acc_upd >= LO_V) && (acc_upd <= HI_V)) : ok_q;
    above_n = hav_vld ? (hav_code > NULL_V) : above_q;
    null_n  = hav_vld && above_q && (hav_code <= NULL_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      acc_q   <= '0;
      peak_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      above_q <= 1'b0;
      null_q  <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_n;
      acc_q   <= acc_n;
      peak_q  <= peak_n;
      done_q  <= done_n;
      ok_q    <= ok_n;
      above_q <= above_n;
      null_q  <= null_n;
    end
  end

  assign peak_o     = peak_q;
  assign win_done_o = done_q;
  assign line_ok_o  = ok_q;
  assign null_o     = null_q;

  // R1
  window_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done_o && line_ok_o) |-> ((peak_o >= LO_V) && (peak_o <= HI_V)));
endmodule

// File: rtl/pfc_ontime.sv
module pfc_ontime #(
  parameter int ADC_W    = 10,
  parameter int BUS_SET  = 806,
  parameter int BUS_OVR  = 870,
  parameter int GAIN_MUL = 3,
  parameter int GAIN_SH  = 2,
  parameter int K_CYC    = 5736,
  parameter int CAP_CYC  = 25,
  parameter int TW       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_vld,
  input  logic [ADC_W-1:0] bus_code,
  input  logic [ADC_W-1:0] peak_i,
  input  logic             null_i,
  output logic [TW-1:0]    ton_o,
  output logic             ovr_o,
  output logic             bus_ok_o
);
  localparam logic [ADC_W-1:0] SET_V = ADC_W'(BUS_SET);
  localparam logic [ADC_W-1:0] OVR_V = ADC_W'(BUS_OVR);

  logic [ADC_W-1:0] bus_q, bus_n;
  logic [TW-1:0]    ton_q, ton_n;
  logic [31:0]      err32, prod32, kmax32, lim32, tnew32;
  logic             ovr;

  always_comb begin
    bus_n    = bus_vld ? bus_code : bus_q;
    ovr      = (bus_q >= OVR_V);
    bus_ok_o = (bus_q >= SET_V) && ((32'(bus_q) * 32'd20) >= (32'(peak_i) * 32'd19));
    err32    = (bus_q < SET_V) ? 32'(SET_V - bus_q) : 32'd0;
    prod32   = (err32 * 32'(GAIN_MUL)) >> GAIN_SH;
    kmax32   = (peak_i == '0) ? 32'(CAP_CYC) : (32'(K_CYC) / 32'(peak_i));
    lim32    = (kmax32 < 32'(CAP_CYC)) ? kmax32 : 32'(CAP_CYC);
    tnew32   = ovr ? 32'd0 : ((prod32 < lim32) ? prod32 : lim32);
    ton_n    = null_i ? tnew32[TW-1:0] : ton_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      ton_q <= '0;
    end else begin
      bus_q <= bus_n;
      ton_q <= ton_n;
    end
  end

  assign ton_o = ton_q;
  assign ovr_o = ovr;

  // R7
  ton_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ton_q) <= 32'(CAP_CYC));
  // R6
  ton_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !null_i |=> $stable(ton_q));
  // R8
  ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (null_i && ovr) |=> (ton_q == '0));
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int SS_ON   = 10,
  parameter int SS_PER  = 50,
  parameter int SS_LEN  = 800,
  parameter int RETRY   = 200,
  parameter int MAX_TRY = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_done_i,
  input  logic       line_ok_i,
  input  logic       zc_i,
  input  logic       bus_ok_i,
  output pfc_state_e state_o,
  output logic       ss_gate_o,
  output logic       line_bad_o
);
  localparam int CMAX = (SS_LEN > RETRY) ? SS_LEN : RETRY;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PW   = $clog2(SS_PER + 1);
  localparam int TRW  = $clog2(MAX_TRY + 1);
  localparam logic [CW-1:0]  SS_LAST  = CW'(SS_LEN - 1);
  localparam logic [CW-1:0]  RT_LAST  = CW'(RETRY - 1);
  localparam logic [PW-1:0]  PER_LAST = PW'(SS_PER - 1);
  localparam logic [PW-1:0]  ON_V     = PW'(SS_ON);
  localparam logic [TRW-1:0] TRY_LAST = TRW'(MAX_TRY - 1);

  pfc_state_e     st_q, st_n;
  logic [CW-1:0]  ccnt_q, ccnt_n;
  logic [PW-1:0]  pcnt_q, pcnt_n;
  logic [TRW-1:0] try_q, try_n;
  logic           zcs_q, zcs_n, bad_q, bad_n;

  always_comb begin
    st_n   = st_q;
    ccnt_n = ccnt_q;
    pcnt_n = pcnt_q;
    try_n  = try_q;
    zcs_n  = zcs_q;
    bad_n  = win_done_i ? !line_ok_i : bad_q;
    case (st_q)
      ST_CHECK: begin
        if (win_done_i && line_ok_i) begin
          st_n = ST_SOFT; ccnt_n = '0; pcnt_n = '0; zcs_n = 1'b0;
        end
      end
      ST_SOFT: begin
        zcs_n = zcs_q | zc_i;
        if ((zcs_q || zc_i) && bus_ok_i) begin
          st_n = ST_RUN; try_n = '0;
        end else if (ccnt_q == SS_LAST) begin
          ccnt_n = '0;
          if (try_q == TRY_LAST) st_n = ST_LOCK;
          else begin
            st_n  = ST_WAIT;
            try_n = try_q + 1'b1;
          end
        end else begin
          ccnt_n = ccnt_q + 1'b1;
          pcnt_n = (pcnt_q == PER_LAST) ? '0 : pcnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (ccnt_q == RT_LAST) begin
          st_n = ST_SOFT; ccnt_n = '0; pcnt_n = '0; zcs_n = 1'b0;
        end else ccnt_n = ccnt_q + 1'b1;
      end
      default: st_n = st_q;
    endcase
    if (win_done_i && !line_ok_i && (st_q != ST_LOCK)) begin
      st_n  = ST_CHECK;
      try_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CHECK;
      ccnt_q <= '0;
      pcnt_q <= '0;
      try_q  <= '0;
      zcs_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ccnt_q <= ccnt_n;
      pcnt_q <= pcnt_n;
      try_q  <= try_n;
      zcs_q  <= zcs_n;
      bad_q  <= bad_n;
    end
  end

  assign state_o    = st_q;
  assign ss_gate_o  = (st_q == ST_SOFT) && (pcnt_q < ON_V);
  assign line_bad_o = bad_q;

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |=> (st_q == ST_LOCK));
  // R5
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && ($past(st_q) != ST_RUN)) |-> ($past(bus_ok_i) && ($past(st_q) == ST_SOFT)));
  // R2
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done_i && !line_ok_i && (st_q != ST_LOCK)) |=> (st_q == ST_CHECK));
endmodule

// File: rtl/pfc_pulse.sv
module pfc_pulse #(
  parameter int TW      = 5,
  parameter int TO_CYC  = 100,
  parameter int CAP_CYC = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          zc_i,
  input  logic [TW-1:0] ton_i,
  output logic          on_o
);
  localparam int CMAX = (TO_CYC > CAP_CYC) ? TO_CYC : CAP_CYC;
  localparam int CNW  = $clog2(CMAX + 1);
  localparam logic [CNW-1:0] TO_LAST = CNW'(TO_CYC - 1);

  logic           on_q, on_n;
  logic [CNW-1:0] cnt_q, cnt_n;
  logic [TW-1:0]  tlat_q, tlat_n;

  always_comb begin
    on_n   = on_q;
    cnt_n  = cnt_q;
    tlat_n = tlat_q;
    if (!en_i) begin
      on_n  = 1'b0;
      cnt_n = '0;
    end else if (on_q) begin
      if ((cnt_q + 1'b1) == CNW'(tlat_q)) begin
        on_n  = 1'b0;
        cnt_n = '0;
      end else cnt_n = cnt_q + 1'b1;
    end else if (zc_i || (cnt_q == TO_LAST)) begin
      cnt_n = '0;
      if (ton_i != '0) begin
        on_n   = 1'b1;
        tlat_n = ton_i;
      end
    end else cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      cnt_q  <= '0;
      tlat_q <= '0;
    end else begin
      on_q   <= on_n;
      cnt_q  <= cnt_n;
      tlat_q <= tlat_n;
    end
  end

  assign on_o = on_q;

  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> ($past(zc_i) || ($past(cnt_q) == TO_LAST)));
  // R9
  width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> (tlat_q != '0));
endmodule

// File: rtl/pfc_crm_ctrl.sv
module pfc_crm_ctrl
  import pfc_pkg::*;
#(
  parameter int ADC_W      = 10,
  parameter int CLK_MHZ    = 50,
  parameter int WIN_US     = 20000,
  parameter int SS_ON_US   = 10,
  parameter int SS_PER_US  = 50,
  parameter int SS_LEN_US  = 800,
  parameter int RETRY_US   = 1000000,
  parameter int MAX_TRY    = 10,
  parameter int TO_US      = 100,
  parameter int TON_K      = 5736,
  parameter int TON_CAP_US = 25,
  parameter int GAIN_MUL   = 3,
  parameter int GAIN_SH    = 2,
  parameter int LINE_LO    = 324,
  parameter int LINE_HI    = 956,
  parameter int BUS_SET    = 806,
  parameter int BUS_OVR    = 870,
  parameter int NULL_TH    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hav_vld,
  input  logic [ADC_W-1:0] hav_code,
  input  logic             bus_vld,
  input  logic [ADC_W-1:0] bus_code,
  input  logic             zc_pulse,
  output logic             gate_drv,
  output logic             pfc_running,
  output logic             pfc_fault
);
  localparam int WIN_CYC = WIN_US * CLK_MHZ;
  localparam int CAP_CYC = TON_CAP_US * CLK_MHZ;
  localparam int K_CYC   = TON_K * CLK_MHZ;
  localparam int TO_CYC  = TO_US * CLK_MHZ;
  localparam int TW      = $clog2(CAP_CYC + 1);

  logic [ADC_W-1:0] peak;
  logic             win_done, line_ok, null_p, ovr, bus_ok, ss_gate, line_bad, p_on;
  logic [TW-1:0]    ton;
  pfc_state_e       st;
  logic             gate_q, gate_n;

  pfc_line_mon #(.ADC_W(ADC_W), .WIN_CYC(WIN_CYC), .LINE_LO(LINE_LO),
                 .LINE_HI(LINE_HI), .NULL_TH(NULL_TH)) u_line (
    .clk(clk), .rst_n(rst_n), .hav_vld(hav_vld), .hav_code(hav_code),
    .peak_o(peak), .win_done_o(win_done), .line_ok_o(line_ok), .null_o(null_p));

  pfc_ontime #(.ADC_W(ADC_W), .BUS_SET(BUS_SET), .BUS_OVR(BUS_OVR),
               .GAIN_MUL(GAIN_MUL), .GAIN_SH(GAIN_SH), .K_CYC(K_CYC),
               .CAP_CYC(CAP_CYC), .TW(TW)) u_ton (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_code(bus_code),
    .peak_i(peak), .null_i(null_p), .ton_o(ton), .ovr_o(ovr), .bus_ok_o(bus_ok));

  pfc_seq #(.SS_ON(SS_ON_US * CLK_MHZ), .SS_PER(SS_PER_US * CLK_MHZ),
            .SS_LEN(SS_LEN_US * CLK_MHZ), .RETRY(RETRY_US * CLK_MHZ),
            .MAX_TRY(MAX_TRY)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_done_i(win_done), .line_ok_i(line_ok),
    .zc_i(zc_pulse), .bus_ok_i(bus_ok), .state_o(st), .ss_gate_o(ss_gate),
    .line_bad_o(line_bad));

  pfc_pulse #(.TW(TW), .TO_CYC(TO_CYC), .CAP_CYC(CAP_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .en_i(st == ST_RUN), .zc_i(zc_pulse),
    .ton_i(ton), .on_o(p_on));

  always_comb begin
    gate_n = ((st == ST_RUN) ? p_on : ss_gate) & ~ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_n;
  end

  assign gate_drv    = gate_q;
  assign pfc_running = (st == ST_RUN);
  assign pfc_fault   = line_bad | (st == ST_LOCK);

  // R8
  gate_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !gate_q);
  // R4
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_LOCK) && $past(st == ST_LOCK)) |-> (!gate_q && pfc_fault));
  // R1
  check_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CHECK) && $past(st == ST_CHECK)) |-> !gate_q);
endmodule

// File: tb/test_pfc_crm_ctrl.sv
`timescale 1ns/1ps
module test_pfc_crm_ctrl;
  localparam int ADC_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             hav_vld, bus_vld, zc_pulse;
  logic [ADC_W-1:0] hav_code, bus_code;
  logic             gate_drv, pfc_running, pfc_fault;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done = 1'b0;

  always #2 clk = ~clk;

  pfc_crm_ctrl #(.ADC_W(ADC_W), .CLK_MHZ(1), .WIN_US(300), .SS_ON_US(10),
    .SS_PER_US(50), .SS_LEN_US(800), .RETRY_US(200), .MAX_TRY(3), .TO_US(100),
    .TON_K(5736), .TON_CAP_US(25), .GAIN_MUL(3), .GAIN_SH(2), .LINE_LO(324),
    .LINE_HI(956), .BUS_SET(806), .BUS_OVR(870), .NULL_TH(16)) i_pfc_crm_ctrl (
    .clk(clk), .rst_n(rst_n), .hav_vld(hav_vld), .hav_code(hav_code),
    .bus_vld(bus_vld), .bus_code(bus_code), .zc_pulse(zc_pulse),
    .gate_drv(gate_drv), .pfc_running(pfc_running), .pfc_fault(pfc_fault));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic do_reset(input int hv, input int bv);
    rst_n = 1'b0; zc_pulse = 1'b0; hav_vld = 1'b1; bus_vld = 1'b1;
    hav_code = ADC_W'(hv); bus_code = ADC_W'(bv);
    tick(4);
    chk(!gate_drv && !pfc_running && !pfc_fault, "R11 reset", {gate_drv, pfc_running, pfc_fault}, 0);
    rst_n = 1'b1;
  endtask

  task automatic zc_once;
    zc_pulse = 1'b1; tick(1); zc_pulse = 1'b0;
  endtask

  task automatic do_null;
    logic [ADC_W-1:0] keep;
    keep = hav_code; hav_code = '0; tick(3); hav_code = keep; tick(1);
  endtask

  task automatic wait_rise(input int maxc, output int t);
    t = 0;
    while (gate_drv !== 1'b1 && t < maxc) begin tick(1); t++; end
  endtask

  task automatic meas_high(output int w);
    w = 0;
    while (gate_drv === 1'b1 && w < 2000) begin tick(1); w++; end
  endtask

  task automatic meas_low(output int w);
    w = 0;
    while (gate_drv === 1'b0 && w < 2000) begin tick(1); w++; end
  endtask

  task automatic count_high(input int n, input bit with_zc, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      zc_pulse = with_zc && (i % 50 == 0);
      tick(1);
      if (gate_drv) h++;
    end
    zc_pulse = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin : main
    int t, w, h, rises, n40, n240, badw, hl, ll;
    bit prev;

    // A: no zero crossing, three failed bursts, problem state
    do_reset(600, 0);
    wait_rise(1000, t);
    chk(t >= 295 && t <= 310, "R1 first pulse after window", t, 302);
    rises = 1; n40 = 0; n240 = 0; badw = 0; hl = 0; ll = 0; prev = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (gate_drv) begin
        if (!prev) begin
          rises++;
          if (ll == 40) n40++; else if (ll == 240) n240++;
          hl = 0;
        end
        hl++;
      end else begin
        if (prev) begin
          if (hl != 10) badw++;
          ll = 0;
        end
        ll++;
      end
      prev = gate_drv;
      tick(1);
    end
    chk(badw == 0, "R3 soft pulse width", badw, 0);
    chk(n40 == 45, "R3 soft period gaps", n40, 45);
    chk(n240 == 2, "R4 retry pause", n240, 2);
    chk(rises == 48, "R4 bounded attempts", rises, 48);
    chk(pfc_fault && !pfc_running, "R4 problem state", pfc_fault, 1);

    // B: closed loop
    do_reset(600, 806);
    wait_rise(1000, t);
    zc_once();
    tick(2);
    chk(pfc_running == 1'b1, "R5 run entry", pfc_running, 1);
    count_high(250, 1'b0, h);
    chk(h == 0, "R6 no on-time before null", h, 0);
    bus_code = 780; tick(3);
    do_null();
    wait_rise(200, t);
    meas_high(w);
    chk(w == 9, "R7 line peak ceiling", w, 9);
    zc_once();
    wait_rise(20, t);
    chk(t <= 4, "R9 start on zero crossing", t, 2);
    zc_once();
    meas_high(w);
    chk(w + 1 == 9, "R9 zc during pulse ignored width", w + 1, 9);
    meas_low(w);
    chk(w == 100, "R10 timeout start", w, 100);
    bus_code = 800; tick(2);
    meas_high(w); meas_low(w); meas_high(w);
    chk(w == 9, "R6 held until null", w, 9);
    do_null();
    if (gate_drv) meas_high(w);
    wait_rise(200, t);
    meas_high(w);
    chk(w == 4, "R6 gain path", w, 4);
    bus_code = 900; tick(3);
    count_high(300, 1'b1, h);
    chk(h == 0, "R8 overshoot blanking", h, 0);
    do_null();
    bus_code = 800; tick(3);
    count_high(300, 1'b1, h);
    chk(h == 0, "R8 zero on-time latched", h, 0);
    do_null();
    wait_rise(200, t);
    meas_high(w);
    chk(w == 4, "R6 recovery after null", w, 4);
    bus_code = 700; hav_code = 340;
    tick(700);
    do_null();
    if (gate_drv) meas_high(w);
    wait_rise(200, t);
    meas_high(w);
    chk(w == 16, "R7 ceiling at low peak", w, 16);
    hav_code = 300;
    t = 0;
    while (!pfc_fault && t < 800) begin tick(1); t++; end
    chk(pfc_fault && !pfc_running, "R2 line drop stops", pfc_fault, 1);
    count_high(200, 1'b1, h);
    chk(h == 0, "R2 halted while out of band", h, 0);
    hav_code = 600;
    wait_rise(800, t);
    chk(gate_drv && !pfc_fault, "R2 restart when back in band", gate_drv, 1);

    // C: bus versus line peak
    do_reset(900, 806);
    wait_rise(1000, t);
    zc_once();
    tick(10);
    chk(!pfc_running, "R5 bus below 0.95 peak", pfc_running, 0);
    bus_code = 860; tick(5);
    chk(pfc_running, "R5 remembered zero crossing", pfc_running, 1);

    // D: line out of band from the start
    do_reset(1000, 806);
    count_high(350, 1'b0, h);
    chk(pfc_fault && h == 0, "R2 high line", h, 0);
    do_reset(300, 806);
    count_high(350, 1'b0, h);
    chk(pfc_fault && h == 0, "R1 low line no switching", h, 0);

    // E: overshoot during soft start
    do_reset(600, 900);
    count_high(1200, 1'b0, h);
    chk(h == 0, "R8 soft start blanked", h, 0);

    done = 1'b1;
    report();
  end
endmodule